// File: doc/BRIEF.md
# Pin Event Interrupts with Auxiliary Output Selector

This block watches a bank of general-purpose input pins. Each pin can raise its own interrupt request on a rising or a falling edge, chosen per pin. The pins pass through a two-flop synchronizer before edge detection. Software clears a request bit by writing 1 to it. A per-pin enable decides whether a pending request reaches an interrupt output. The enabled requests are ORed into one source line, which feeds the chip's main interrupt logic.

A second output, the auxiliary pin, is driven through a 2-bit selector. It can show:
- the operating (power-good) flag;
- the bus-voltage-detect flag;
- bus activity;
- a square wave that toggles on each frame-start strobe.

In the bus-activity slot, a separate-interrupt flag turns the auxiliary pin into a second interrupt pin for the pin events alone. In that case the pin events leave the main interrupt source. The auxiliary pin then follows the main interrupt pin's level-or-edge mode and edge polarity, which arrive as inputs.

Top module: `gpin_event_aux`

## Requirements
- R1: After reset, every request bit is 0, `main_src_o` is 0 and the square-wave state is 0, so `aux_o` reads 0 with selector 3.
- R2: A bit of `pol_i` at 1 selects the rising edge for that pin and 0 selects the falling edge. A selected edge on `pin_i[i]` sets `req_o[i]` on the third rising clock edge after the pin changes. An edge of the other direction leaves the bit unchanged.
- R3: A cycle with `clr_we_i` high clears every request bit whose `clr_mask_i` bit is 1. If a selected edge on a pin is detected in the same cycle as its clear, the bit ends set.
- R4: `main_src_o` is 1 exactly when some bit is set in both `req_o` and `en_i` and `sep_irq_i` is 0. Disabled pins still set their bits in `req_o`.
- R5: Selector value 0 drives `aux_o` from `pwr_ok_i`, and selector value 1 drives it from `vbus_det_i`.
- R6: Selector value 2 with `sep_irq_i` at 0 drives `aux_o` from `bus_act_i`.
- R7: Selector value 2 with `sep_irq_i` at 1 and `irq_level_i` at 1 drives `aux_o` low while any enabled request is pending, and high otherwise.
- R8: Selector value 2 with `sep_irq_i` at 1 and `irq_level_i` at 0 gives edge mode. The idle level is the inverse of `irq_pos_i`. `aux_o` shows a one-cycle active pulse one cycle after a request bit becomes set-and-enabled where it was not in the previous cycle.
- R9: Selector value 3 drives a square wave that inverts on the clock edge at which `frame_stb_i` is high.
- R10: With no detected edge and no clear, every request bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | General-purpose input pins (asynchronous) |
| pol_i | input | 8 | Per-pin edge select: 1 rising, 0 falling |
| en_i | input | 8 | Per-pin interrupt enable |
| clr_we_i | input | 1 | Write strobe for request clear |
| clr_mask_i | input | 8 | Write-1-to-clear mask |
| sel_i | input | 2 | Auxiliary output selector |
| sep_irq_i | input | 1 | Steer pin events to the auxiliary pin |
| irq_level_i | input | 1 | Main interrupt pin mode: 1 level, 0 edge |
| irq_pos_i | input | 1 | Edge-mode pulse polarity: 1 positive |
| pwr_ok_i | input | 1 | Device operating flag |
| vbus_det_i | input | 1 | Bus-voltage-detect flag |
| bus_act_i | input | 1 | Bus activity flag |
| frame_stb_i | input | 1 | One-cycle frame-start strobe |
| aux_o | output | 1 | Auxiliary output pin |
| main_src_o | output | 1 | OR of enabled requests for the main interrupt logic |
| req_o | output | 8 | Readable request bits |

## Verification
Directed cases drive single pins through rising and falling transitions under each polarity. They show that only the selected edge is latched, and latched exactly three clocks after the pin change. A clear that lands in the same cycle as an edge shows that set wins over clear. Each selector value is then stepped with its source toggled, separating the four auxiliary modes and the level and edge variants of the second interrupt pin. A seeded random phase changes pins, polarities, enables, clears, selector and strobes every cycle. Every output is compared against a cycle model in the bench, which exposes mixing errors between the enable, clear and steering paths.

// File: rtl/gpin_event_pkg.sv
package gpin_event_pkg;
    localparam int unsigned NPIN = 8;

    typedef enum logic [1:0] {
        AUX_PWR   = 2'd0,
        AUX_VBUS  = 2'd1,
        AUX_ACT   = 2'd2,
        AUX_FRAME = 2'd3
    } aux_sel_e;
endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpin_req.sv
module gpin_req #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] req_o
);
    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] req;
    } req_t;

    req_t         st_d, st_q;
    logic [W-1:0] hit;
    logic [W-1:0] wipe;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign hit[i] = pol_i[i] ? (lvl_i[i] & ~st_q.last[i])
                                 : (~lvl_i[i] & st_q.last[i]);
    end

    assign wipe = clr_we_i ? clr_mask_i : '0;

    always_comb begin
        st_d      = st_q;
        st_d.last = lvl_i;
        st_d.req  = (st_q.req & ~wipe) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = hit;
    assign req_o = st_q.req;
endmodule

// File: rtl/gpin_aux.sv
module gpin_aux
    import gpin_event_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] en_i,
    input  logic         sep_irq_i,
    input  logic         irq_level_i,
    input  logic         irq_pos_i,
    input  logic [1:0]   sel_i,
    input  logic         pwr_ok_i,
    input  logic         vbus_det_i,
    input  logic         bus_act_i,
    input  logic         frame_stb_i,
    output logic         aux_o,
    output logic         main_src_o
);
    typedef struct packed {
        logic         sq;
        logic [W-1:0] seen;
        logic         pulse;
    } aux_t;

    aux_t         st_d, st_q;
    logic [W-1:0] live;
    logic         pend;
    logic         irq2;

    assign live = req_i & en_i;
    assign pend = |live;

    always_comb begin
        st_d       = st_q;
        st_d.sq    = st_q.sq ^ frame_stb_i;
        st_d.seen  = live;
        st_d.pulse = |(live & ~st_q.seen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (irq_level_i) irq2 = ~pend;
        else             irq2 = irq_pos_i ? st_q.pulse : ~st_q.pulse;
    end

    always_comb begin
        unique case (aux_sel_e'(sel_i))
            AUX_PWR:   aux_o = pwr_ok_i;
            AUX_VBUS:  aux_o = vbus_det_i;
            AUX_ACT:   aux_o = sep_irq_i ? irq2 : bus_act_i;
            AUX_FRAME: aux_o = st_q.sq;
            default:   aux_o = 1'b0;
        endcase
    end

    assign main_src_o = pend & ~sep_irq_i;
endmodule

// File: rtl/gpin_event_aux.sv
module gpin_event_aux
    import gpin_event_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] pol_i,
    input  logic [NPIN-1:0] en_i,
    input  logic            clr_we_i,
    input  logic [NPIN-1:0] clr_mask_i,
    input  logic [1:0]      sel_i,
    input  logic            sep_irq_i,
    input  logic            irq_level_i,
    input  logic            irq_pos_i,
    input  logic            pwr_ok_i,
    input  logic            vbus_det_i,
    input  logic            bus_act_i,
    input  logic            frame_stb_i,
    output logic            aux_o,
    output logic            main_src_o,
    output logic [NPIN-1:0] req_o
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] edge_hit;

    gpin_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gpin_req #(.W(NPIN)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (pin_sync),
        .pol_i      (pol_i),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .hit_o      (edge_hit),
        .req_o      (req_o)
    );

    gpin_aux #(.W(NPIN)) u_aux (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_o),
        .en_i        (en_i),
        .sep_irq_i   (sep_irq_i),
        .irq_level_i (irq_level_i),
        .irq_pos_i   (irq_pos_i),
        .sel_i       (sel_i),
        .pwr_ok_i    (pwr_ok_i),
        .vbus_det_i  (vbus_det_i),
        .bus_act_i   (bus_act_i),
        .frame_stb_i (frame_stb_i),
        .aux_o       (aux_o),
        .main_src_o  (main_src_o)
    );
endmodule

// File: rtl/gpin_event_aux_chk.sv
module gpin_event_aux_chk
    import gpin_event_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] edge_hit,
    input logic            clr_we_i,
    input logic [NPIN-1:0] clr_mask_i,
    input logic [1:0]      sel_i,
    input logic            sep_irq_i,
    input logic            pwr_ok_i,
    input logic            vbus_det_i,
    input logic            bus_act_i,
    input logic            frame_stb_i,
    input logic            aux_o,
    input logic            main_src_o,
    input logic [NPIN-1:0] req_o
);
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((req_o & $past(edge_hit)) == $past(edge_hit)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((req_o & $past(clr_mask_i & ~edge_hit)) == '0));

    a_r4_steer_off: assert property (@(posedge clk) disable iff (!rst_n)
        sep_irq_i |-> !main_src_o);

    a_r5_pwr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd0) |-> (aux_o == pwr_ok_i));

    a_r5_vbus_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd1) |-> (aux_o == vbus_det_i));

    a_r6_act_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd2 && !sep_irq_i) |-> (aux_o == bus_act_i));

    a_r9_square_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb_i && sel_i == 2'd3) |=> (sel_i != 2'd3 || aux_o != $past(aux_o)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && edge_hit == '0) |=> $stable(req_o));
endmodule

bind gpin_event_aux gpin_event_aux_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_hit    (edge_hit),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .sel_i       (sel_i),
    .sep_irq_i   (sep_irq_i),
    .pwr_ok_i    (pwr_ok_i),
    .vbus_det_i  (vbus_det_i),
    .bus_act_i   (bus_act_i),
    .frame_stb_i (frame_stb_i),
    .aux_o       (aux_o),
    .main_src_o  (main_src_o),
    .req_o       (req_o)
);

// File: tb/gpin_event_aux_bench.sv
module gpin_event_aux_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0, pol_i = '0, en_i = '0, clr_mask_i = '0;
    logic       clr_we_i = 1'b0;
    logic [1:0] sel_i = 2'd3;
    logic       sep_irq_i = 1'b0, irq_level_i = 1'b1, irq_pos_i = 1'b1;
    logic       pwr_ok_i = 1'b0, vbus_det_i = 1'b0, bus_act_i = 1'b0, frame_stb_i = 1'b0;
    logic       aux_o, main_src_o;
    logic [7:0] req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpin_event_aux u_gpin_event_aux (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol_i), .en_i(en_i),
        .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .sel_i(sel_i),
        .sep_irq_i(sep_irq_i), .irq_level_i(irq_level_i), .irq_pos_i(irq_pos_i),
        .pwr_ok_i(pwr_ok_i), .vbus_det_i(vbus_det_i), .bus_act_i(bus_act_i),
        .frame_stb_i(frame_stb_i), .aux_o(aux_o), .main_src_o(main_src_o),
        .req_o(req_o)
    );

    // Cycle model built from the requirements
    logic [7:0] m_s1, m_s2, m_s3, m_req, m_seen;
    logic       m_pulse, m_sq;

    function automatic logic [7:0] edges(input logic [7:0] cur, input logic [7:0] prv,
                                         input logic [7:0] pol);
        return (pol & cur & ~prv) | (~pol & ~cur & prv);
    endfunction

    function automatic logic exp_aux();
        logic irq2;
        irq2 = irq_level_i ? ~|(m_req & en_i) : (irq_pos_i ? m_pulse : ~m_pulse);
        case (sel_i)
            2'd0: return pwr_ok_i;
            2'd1: return vbus_det_i;
            2'd2: return sep_irq_i ? irq2 : bus_act_i;
            default: return m_sq;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_req <= '0;
            m_seen <= '0; m_pulse <= 1'b0; m_sq <= 1'b0;
        end else begin
            m_s1    <= pin_i;
            m_s2    <= m_s1;
            m_s3    <= m_s2;
            m_req   <= (m_req & ~(clr_we_i ? clr_mask_i : 8'h00)) | edges(m_s2, m_s3, pol_i);
            m_seen  <= m_req & en_i;
            m_pulse <= |(m_req & en_i & ~m_seen);
            m_sq    <= m_sq ^ frame_stb_i;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear(input logic [7:0] m);
        clr_we_i = 1'b1; clr_mask_i = m;
        tick(1);
        clr_we_i = 1'b0; clr_mask_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 req", req_o, 0);
        check("R1 main", main_src_o, 0);
        check("R1 square", aux_o, 0);

        pol_i = 8'hFD; en_i = 8'hFF;
        // R2 rising edge, latency
        pin_i[0] = 1'b1;
        tick(2);
        check("R2 not yet", req_o, 0);
        tick(1);
        check("R2 rise", req_o, 8'h01);
        check("R4 main on", main_src_o, 1);
        // R3 clear
        clear(8'h01);
        check("R3 cleared", req_o, 0);
        // R2 opposite edge ignored
        pin_i[0] = 1'b0;
        tick(3);
        check("R2 fall ignored", req_o, 0);
        // R2 falling polarity on pin 1
        pin_i[1] = 1'b1;
        tick(3);
        check("R2 rise ignored pol0", req_o, 0);
        pin_i[1] = 1'b0;
        tick(3);
        check("R2 fall", req_o, 8'h02);
        // R4 enable and steering
        en_i = 8'h00;
        tick(1);
        check("R4 disabled", main_src_o, 0);
        check("R4 still set", req_o, 8'h02);
        en_i = 8'hFF; sep_irq_i = 1'b1;
        tick(1);
        check("R4 steered", main_src_o, 0);
        sep_irq_i = 1'b0;
        // R3 edge and clear on same cycle
        pin_i[2] = 1'b1;
        tick(2);
        clear(8'hFF);
        check("R3 set wins", req_o, 8'h04);
        // R10 hold
        tick(20);
        check("R10 hold", req_o, 8'h04);
        // R5 / R6 pass-through
        sel_i = 2'd0; pwr_ok_i = 1'b1; #1;
        check("R5 pwr hi", aux_o, 1);
        pwr_ok_i = 1'b0; #1;
        check("R5 pwr lo", aux_o, 0);
        sel_i = 2'd1; vbus_det_i = 1'b1; #1;
        check("R5 vbus", aux_o, 1);
        sel_i = 2'd2; bus_act_i = 1'b1; #1;
        check("R6 act", aux_o, 1);
        bus_act_i = 1'b0; #1;
        check("R6 act lo", aux_o, 0);
        // R7 level mode second interrupt
        sep_irq_i = 1'b1; irq_level_i = 1'b1; #1;
        check("R7 pending low", aux_o, 0);
        clear(8'hFF);
        check("R7 idle high", aux_o, 1);
        // R8 edge mode
        irq_level_i = 1'b0; irq_pos_i = 1'b1; tick(1);
        check("R8 idle", aux_o, 0);
        pin_i[3] = 1'b1;
        tick(3);
        check("R8 before pulse", aux_o, 0);
        tick(1);
        check("R8 pulse", aux_o, 1);
        tick(1);
        check("R8 one cycle", aux_o, 0);
        irq_pos_i = 1'b0; #1;
        check("R8 idle neg", aux_o, 1);
        // R9 square wave
        sel_i = 2'd3; #1;
        check("R9 start", aux_o, 0);
        frame_stb_i = 1'b1; tick(1); frame_stb_i = 1'b0;
        check("R9 rise", aux_o, 1);
        tick(3);
        check("R9 hold", aux_o, 1);
        frame_stb_i = 1'b1; tick(1); frame_stb_i = 1'b0;
        check("R9 fall", aux_o, 0);

        // Random phase against the model
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < RAND_CYCLES; k++) begin
            pin_i       = pin_i ^ (8'($urandom) & 8'($urandom));
            if ($urandom_range(0, 15) == 0) pol_i = 8'($urandom);
            if ($urandom_range(0, 15) == 0) en_i  = 8'($urandom);
            clr_we_i    = ($urandom_range(0, 5) == 0);
            clr_mask_i  = 8'($urandom);
            if ($urandom_range(0, 31) == 0) sel_i = 2'($urandom);
            if ($urandom_range(0, 31) == 0) sep_irq_i = 1'($urandom);
            if ($urandom_range(0, 31) == 0) irq_level_i = 1'($urandom);
            if ($urandom_range(0, 31) == 0) irq_pos_i = 1'($urandom);
            pwr_ok_i    = 1'($urandom);
            vbus_det_i  = 1'($urandom);
            bus_act_i   = 1'($urandom);
            frame_stb_i = ($urandom_range(0, 7) == 0);
            #1;
            check("R2 R3 R10 random req", req_o, m_req);
            check("R4 random main", main_src_o, |(m_req & en_i) & ~sep_irq_i);
            check("R5 R6 R7 R8 R9 random aux", aux_o, exp_aux());
            tick(1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule